// File: doc/BRIEF.md
# Pipelined Self-Routing Shuffle-Exchange Network

This block moves up to N words per clock from N source lines to N destination lines. Each word carries its own destination index. It passes through log2(N) columns of 2x2 exchange cells. Ahead of every column, the lines are reordered by a perfect shuffle, which rotates the binary line index left by one place. Each cell looks at one destination bit and sends the word to its upper or lower output. The first column uses the most significant bit, and each later column uses the next bit down.

Every column ends in a register, so a batch of words presented in one cycle moves through the network as a unit. Batches presented in different cycles never interact. When both words at a cell want the same output, the word on the cell's upper input continues and the other word is discarded. The discard is reported on a pulse output that belongs to that cell, together with the destination of the discarded word.

The interface carries a valid flag only. There is no ready signal and no back-pressure. A destination port must accept its word in the cycle the word appears, and a discarded word is lost. Retrying discarded words is left to the logic around the block.

Top module: `omega_net`

## Requirements
- R1: The network has LG = log2(N) register columns. A word presented with `in_valid` high in cycle t that is not discarded appears on the output side in cycle t+LG. No output or discard is ever raised more than LG cycles after the last valid input.
- R2: A word delivered on output port p always carries destination p. Port p's destination sits at `out_dst[p*LG +: LG]`.
- R3: Column s (0 = first) first reorders its input lines so that line i moves to line ((i<<1) | (i>>(LG-1))) mod N. Cell x of that column then takes lines 2x (upper) and 2x+1 (lower). It steers each word by destination bit LG-1-s: 0 goes to output line 2x and 1 goes to output line 2x+1.
- R4: When both inputs of a cell are valid and their steering bits are equal, the word on the upper input is forwarded and the lower one is discarded.
- R5: A discard at cell x of column s raises `drop_valid[s*N/2 + x]` for one cycle, s+1 cycles after the batch entered. In the same cycle, `drop_dst[(s*N/2+x)*LG +: LG]` holds the discarded word's destination.
- R6: While `rst_n` is low at a rising edge, every valid bit in the network is cleared. `out_valid` and `drop_valid` are therefore all zero in the following cycle.
- R7: An invalid input produces no output and no discard. An idle input batch yields all-zero `out_valid` and `drop_valid` in the cycles where its results are due.
- R8: The payload of a delivered word is unchanged from entry to exit. Port p's payload sits at `out_data[p*DW +: DW]`, and input line i uses `in_dst[i*LG +: LG]` and `in_data[i*DW +: DW]`.
- R9: A cell with only one valid input never discards, whatever the steering bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Word present on each source line |
| in_dst | input | N*LG | Destination index per source line |
| in_data | input | N*DW | Payload per source line |
| out_valid | output | N | Word present on each destination port |
| out_dst | output | N*LG | Destination carried by each delivered word |
| out_data | output | N*DW | Payload per destination port |
| drop_valid | output | LG*N/2 | One-cycle discard pulse per cell, column-major |
| drop_dst | output | LG*N/2*LG | Destination of the discarded word per cell |

## Verification
The outputs of a batch presented in cycle t are due in cycle t+LG, and a discard in column s is due in cycle t+s+1. The bench drives a new batch every cycle just after the falling edge. On each falling edge, it compares the ports against a reference model result chosen by that age: the batch presented LG cycles earlier for the outputs, and the batch presented s+1 cycles earlier for the discard slice of column s. Directed batches fix a known collision in the first column and a non-colliding pair in the same cell. Random full permutations and randomly masked conflicting traffic fill the rest.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Perfect-shuffle target of line i in an lg-bit index space.
  function automatic int shuffle_to(input int i, input int lg);
    return ((i << 1) | (i >> (lg - 1))) & ((1 << lg) - 1);
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch #(
  parameter int LG  = 3,
  parameter int DW  = 16,
  parameter int SEL = 2
) (
  input  logic          a_vld,
  input  logic [LG-1:0] a_dst,
  input  logic [DW-1:0] a_dat,
  input  logic          b_vld,
  input  logic [LG-1:0] b_dst,
  input  logic [DW-1:0] b_dat,
  output logic          up_vld,
  output logic [LG-1:0] up_dst,
  output logic [DW-1:0] up_dat,
  output logic          lo_vld,
  output logic [LG-1:0] lo_dst,
  output logic [DW-1:0] lo_dat,
  output logic          clash,
  output logic [LG-1:0] clash_dst
);

  logic a_low, b_low;

  assign a_low = a_dst[SEL];
  assign b_low = b_dst[SEL];

  always_comb begin
    up_vld = 1'b0;
    up_dst = '0;
    up_dat = '0;
    lo_vld = 1'b0;
    lo_dst = '0;
    lo_dat = '0;
    // upper input has priority on each output
    if (a_vld && !a_low) begin
      up_vld = 1'b1;
      up_dst = a_dst;
      up_dat = a_dat;
    end else if (b_vld && !b_low) begin
      up_vld = 1'b1;
      up_dst = b_dst;
      up_dat = b_dat;
    end
    if (a_vld && a_low) begin
      lo_vld = 1'b1;
      lo_dst = a_dst;
      lo_dat = a_dat;
    end else if (b_vld && b_low) begin
      lo_vld = 1'b1;
      lo_dst = b_dst;
      lo_dat = b_dat;
    end
  end

  assign clash     = a_vld && b_vld && (a_low == b_low);
  assign clash_dst = b_dst;

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int N   = 8,
  parameter int LG  = 3,
  parameter int DW  = 16,
  parameter int STG = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      prv_vld,
  input  logic [N*LG-1:0]   prv_dst,
  input  logic [N*DW-1:0]   prv_dat,
  output logic [N-1:0]      nxt_vld,
  output logic [N*LG-1:0]   nxt_dst,
  output logic [N*DW-1:0]   nxt_dat,
  output logic [N/2-1:0]    drp_vld,
  output logic [N/2*LG-1:0] drp_dst
);

  localparam int H   = N / 2;
  localparam int SEL = LG - 1 - STG;

  logic [N-1:0]    sh_vld, sw_vld;
  logic [N*LG-1:0] sh_dst, sw_dst;
  logic [N*DW-1:0] sh_dat, sw_dat;
  logic [H-1:0]    cl_vld;
  logic [H*LG-1:0] cl_dst;

  // perfect-shuffle wiring ahead of the exchange cells
  for (genvar i = 0; i < N; i++) begin : g_shuf
    localparam int J = omega_pkg::shuffle_to(i, LG);
    assign sh_vld[J]           = prv_vld[i];
    assign sh_dst[J*LG +: LG]  = prv_dst[i*LG +: LG];
    assign sh_dat[J*DW +: DW]  = prv_dat[i*DW +: DW];
  end

  for (genvar x = 0; x < H; x++) begin : g_cell
    omega_switch #(.LG(LG), .DW(DW), .SEL(SEL)) cell_i (
      .a_vld     (sh_vld[2*x]),
      .a_dst     (sh_dst[(2*x)*LG +: LG]),
      .a_dat     (sh_dat[(2*x)*DW +: DW]),
      .b_vld     (sh_vld[2*x+1]),
      .b_dst     (sh_dst[(2*x+1)*LG +: LG]),
      .b_dat     (sh_dat[(2*x+1)*DW +: DW]),
      .up_vld    (sw_vld[2*x]),
      .up_dst    (sw_dst[(2*x)*LG +: LG]),
      .up_dat    (sw_dat[(2*x)*DW +: DW]),
      .lo_vld    (sw_vld[2*x+1]),
      .lo_dst    (sw_dst[(2*x+1)*LG +: LG]),
      .lo_dat    (sw_dat[(2*x+1)*DW +: DW]),
      .clash     (cl_vld[x]),
      .clash_dst (cl_dst[x*LG +: LG])
    );
  end

  // valid bits are reset, payload registers are not
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_vld <= '0;
      drp_vld <= '0;
    end else begin
      nxt_vld <= sw_vld;
      drp_vld <= cl_vld;
    end
  end

  always_ff @(posedge clk) begin
    nxt_dst <= sw_dst;
    nxt_dat <= sw_dat;
    drp_dst <= cl_dst;
  end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int N  = 8,
  parameter int DW = 16,
  localparam int LG = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          in_valid,
  input  logic [N*LG-1:0]       in_dst,
  input  logic [N*DW-1:0]       in_data,
  output logic [N-1:0]          out_valid,
  output logic [N*LG-1:0]       out_dst,
  output logic [N*DW-1:0]       out_data,
  output logic [LG*N/2-1:0]     drop_valid,
  output logic [LG*N/2*LG-1:0]  drop_dst
);

  localparam int H = N / 2;

  logic [N-1:0]    ln_vld [LG+1];
  logic [N*LG-1:0] ln_dst [LG+1];
  logic [N*DW-1:0] ln_dat [LG+1];

  assign ln_vld[0] = in_valid;
  assign ln_dst[0] = in_dst;
  assign ln_dat[0] = in_data;

  for (genvar s = 0; s < LG; s++) begin : g_col
    omega_stage #(.N(N), .LG(LG), .DW(DW), .STG(s)) stage_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .prv_vld (ln_vld[s]),
      .prv_dst (ln_dst[s]),
      .prv_dat (ln_dat[s]),
      .nxt_vld (ln_vld[s+1]),
      .nxt_dst (ln_dst[s+1]),
      .nxt_dat (ln_dat[s+1]),
      .drp_vld (drop_valid[s*H +: H]),
      .drp_dst (drop_dst[s*H*LG +: H*LG])
    );
  end

  assign out_valid = ln_vld[LG];
  assign out_dst   = ln_dst[LG];
  assign out_data  = ln_dat[LG];

endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int LG = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         in_valid,
  input logic [N-1:0]         out_valid,
  input logic [N*LG-1:0]      out_dst,
  input logic [LG*N/2-1:0]    drop_valid,
  input logic [LG*N/2*LG-1:0] drop_dst
);

  localparam int H = N / 2;

  logic [7:0] quiet;

  always_ff @(posedge clk) begin
    if (!rst_n) quiet <= 8'(LG);
    else if (|in_valid) quiet <= '0;
    else if (quiet < 8'(LG)) quiet <= quiet + 8'd1;
  end

  // Destination bits already consumed by earlier columns must match the cell index.
  function automatic logic path_ok(input int s, input int x, input logic [LG-1:0] d);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < s; k++)
      if (((x >> k) & 1) != int'(d[LG-s+k])) ok = 1'b0;
    return ok;
  endfunction

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (out_valid == '0 && drop_valid == '0));

  // R1
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet >= 8'(LG)) |-> (out_valid == '0 && drop_valid == '0));

  for (genvar p = 0; p < N; p++) begin : g_port
    // R2
    port_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[p] |-> (out_dst[p*LG +: LG] == LG'(p)));
  end

  for (genvar s = 1; s < LG; s++) begin : g_ds
    for (genvar x = 0; x < H; x++) begin : g_dx
      // R3
      drop_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_valid[s*H+x] |-> path_ok(s, x, drop_dst[(s*H+x)*LG +: LG]));
    end
  end

endmodule

bind omega_net omega_net_chk #(.N(N), .DW(DW), .LG(LG)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_dst    (out_dst),
  .drop_valid (drop_valid),
  .drop_dst   (drop_dst)
);

// File: tb/omega_net_tb.sv
`timescale 1ns/1ps
module omega_net_tb_top;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int LG = $clog2(N);
  localparam int H  = N / 2;
  localparam int NB = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0]         in_valid;
  logic [N*LG-1:0]      in_dst;
  logic [N*DW-1:0]      in_data;
  logic [N-1:0]         out_valid;
  logic [N*LG-1:0]      out_dst;
  logic [N*DW-1:0]      out_data;
  logic [LG*H-1:0]      drop_valid;
  logic [LG*H*LG-1:0]   drop_dst;

  omega_net #(.N(N), .DW(DW)) dut_i (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [N-1:0]       s_v [NB];
  logic [N*LG-1:0]    s_d [NB];
  logic [N*DW-1:0]    s_x [NB];
  logic [N-1:0]       e_ov [NB];
  logic [N*DW-1:0]    e_ox [NB];
  logic [LG*H-1:0]    e_dv [NB];
  logic [LG*H*LG-1:0] e_dd [NB];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int rot(input int i);
    return ((i * 2) % N) + (i / (N / 2));
  endfunction

  // Reference model of shuffle, steer and priority discard.
  task automatic model(input int b);
    int v[N], d[N], tv[N], td[N];
    logic [DW-1:0] x[N], tx[N];
    e_ov[b] = '0; e_ox[b] = '0; e_dv[b] = '0; e_dd[b] = '0;
    for (int i = 0; i < N; i++) begin
      v[i] = s_v[b][i];
      d[i] = int'(s_d[b][i*LG +: LG]);
      x[i] = s_x[b][i*DW +: DW];
    end
    for (int s = 0; s < LG; s++) begin
      for (int i = 0; i < N; i++) begin
        tv[rot(i)] = v[i]; td[rot(i)] = d[i]; tx[rot(i)] = x[i];
      end
      for (int i = 0; i < N; i++) v[i] = 0;
      for (int c = 0; c < H; c++) begin
        int ba, bb;
        ba = (td[2*c]   >> (LG-1-s)) & 1;
        bb = (td[2*c+1] >> (LG-1-s)) & 1;
        if (tv[2*c] != 0) begin
          v[2*c+ba] = 1; d[2*c+ba] = td[2*c]; x[2*c+ba] = tx[2*c];
        end
        if (tv[2*c+1] != 0) begin
          if (tv[2*c] != 0 && ba == bb) begin
            e_dv[b][s*H+c] = 1'b1;
            e_dd[b][(s*H+c)*LG +: LG] = LG'(td[2*c+1]);
          end else begin
            v[2*c+bb] = 1; d[2*c+bb] = td[2*c+1]; x[2*c+bb] = tx[2*c+1];
          end
        end
      end
    end
    for (int p = 0; p < N; p++) begin
      e_ov[b][p] = (v[p] != 0);
      if (v[p] != 0) e_ox[b][p*DW +: DW] = x[p];
    end
  endtask

  task automatic check_at(input int t);
    int ob;
    logic [N-1:0] eov;
    ob  = t - LG;
    eov = (ob >= 0 && ob < NB) ? e_ov[ob] : '0;
    // R1 R7: delivery pattern due LG cycles after entry
    chk(out_valid == eov, "R1/R7 out_valid", 64'(out_valid), 64'(eov));
    for (int p = 0; p < N; p++) begin
      if (eov[p] && out_valid[p]) begin
        chk(out_dst[p*LG +: LG] == LG'(p), "R2 port dst", 64'(out_dst[p*LG +: LG]), 64'(p));
        chk(out_data[p*DW +: DW] == e_ox[ob][p*DW +: DW], "R8 payload",
            64'(out_data[p*DW +: DW]), 64'(e_ox[ob][p*DW +: DW]));
      end
    end
    for (int s = 0; s < LG; s++) begin
      int db;
      logic [H-1:0] edv;
      db  = t - (s + 1);
      edv = (db >= 0 && db < NB) ? e_dv[db][s*H +: H] : '0;
      // R3 R4 R5: discard pattern of column s due s+1 cycles after entry
      chk(drop_valid[s*H +: H] == edv, "R5 drop_valid", 64'(drop_valid[s*H +: H]), 64'(edv));
      for (int c = 0; c < H; c++)
        if (edv[c] && drop_valid[s*H+c])
          chk(drop_dst[(s*H+c)*LG +: LG] == e_dd[db][(s*H+c)*LG +: LG], "R5 drop_dst",
              64'(drop_dst[(s*H+c)*LG +: LG]), 64'(e_dd[db][(s*H+c)*LG +: LG]));
    end
  endtask

  initial begin
    int perm[N];
    in_valid = '0; in_dst = '0; in_data = '0;
    void'($urandom(32'd20250611));
    for (int b = 0; b < NB; b++) begin
      s_v[b] = '0; s_d[b] = '0; s_x[b] = '0;
      for (int i = 0; i < N; i++) s_x[b][i*DW +: DW] = DW'($urandom);
      if (b == 1) begin
        // lines 0 and 4 meet at cell 0 of column 0, both bound for 5
        s_v[b][0] = 1'b1; s_d[b][0*LG +: LG] = LG'(5); s_x[b][0*DW +: DW] = 16'hA0A0;
        s_v[b][4] = 1'b1; s_d[b][4*LG +: LG] = LG'(5); s_x[b][4*DW +: DW] = 16'hB4B4;
      end else if (b == 2) begin
        s_v[b][0] = 1'b1; s_d[b][0*LG +: LG] = LG'(0);
        s_v[b][4] = 1'b1; s_d[b][4*LG +: LG] = LG'(4);
      end else if (b >= 4 && b < 100) begin
        for (int i = 0; i < N; i++) perm[i] = i;
        for (int i = N - 1; i > 0; i--) begin
          int j, tmp;
          j = int'($urandom_range(i, 0));
          tmp = perm[i]; perm[i] = perm[j]; perm[j] = tmp;
        end
        s_v[b] = '1;
        for (int i = 0; i < N; i++) s_d[b][i*LG +: LG] = LG'(perm[i]);
      end else if (b >= 100) begin
        s_v[b] = N'($urandom);
        for (int i = 0; i < N; i++) s_d[b][i*LG +: LG] = LG'($urandom);
      end
      model(b);
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R6: reset state
    chk(out_valid == '0, "R6 reset out_valid", 64'(out_valid), 64'(0));
    chk(drop_valid == '0, "R6 reset drop_valid", 64'(drop_valid), 64'(0));
    rst_n = 1'b1;

    for (int t = 0; t <= NB + LG; t++) begin
      @(negedge clk);
      check_at(t);
      if (t == 2) begin
        // R4: lower contender for port 5 discarded in column 0
        chk(drop_valid[0] == 1'b1, "R4 drop raised", 64'(drop_valid[0]), 64'(1));
        chk(drop_dst[0 +: LG] == LG'(5), "R4 drop dst", 64'(drop_dst[0 +: LG]), 64'(5));
      end
      if (t == 1 + LG)
        chk(out_valid[5] && out_data[5*DW +: DW] == 16'hA0A0, "R4 upper wins",
            64'(out_data[5*DW +: DW]), 64'hA0A0);
      if (t == 2 + LG) begin
        // R9: single contender per steering bit, no discard
        chk(out_valid[0] && out_valid[4], "R9 both delivered", 64'(out_valid), 64'h11);
      end
      if (t == 3)
        chk(drop_valid[0] == 1'b0, "R9 no drop", 64'(drop_valid[0]), 64'(0));
      if (t < NB) begin
        in_valid = s_v[t]; in_dst = s_d[t]; in_data = s_x[t];
      end else begin
        in_valid = '0; in_dst = '0; in_data = '0;
      end
    end

    // R6: reset while traffic is in flight
    in_valid = '1;
    for (int i = 0; i < N; i++) in_dst[i*LG +: LG] = LG'(i);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == '0, "R6 mid reset out_valid", 64'(out_valid), 64'(0));
    chk(drop_valid == '0, "R6 mid reset drop_valid", 64'(drop_valid), 64'(0));
    in_valid = '0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule